// File: doc/BRIEF.md
# Software Write-Protection Sequence Guard

This block watches the stream of write cycles that a host issues towards a byte-wide non-volatile array. Each cycle carries an address and a data byte. The block decides which of those writes may reach the page write controller. It keeps one mode bit, software protection. While the bit is clear, ordinary writes go through unchanged. While it is set, a write goes through only if a three-cycle command prefix came just before it, or if it falls inside the page-load window that such a write opens.

The same three-cycle prefix also sets protection. Protection becomes active only when the prefix is followed by a real data write. A prefix with no data write after it leaves the mode unchanged. A separate six-cycle command clears protection. No byte that advances either command sequence is forwarded to the array.

A write that breaks a sequence part-way sends the matcher back to idle. That write is then handled like any other write in the current mode. Forwarded writes appear at the outputs one clock after the write is sampled.

Top module: `swp_guard`

## Requirements
- R1: While reset is asserted and after reset is released, `prot_on` is 0 and `prog_we` is 0. Reset also clears protection that was set before it.
- R2: With protection clear, a write that is not a command step is forwarded. In the cycle after the write, `prog_we` is 1 and `prog_addr`/`prog_data` equal the sampled address and data. `prog_we` is never 1 without a write in the previous cycle.
- R3: A write that advances a command sequence is never forwarded. The command steps are data 0xAA at address 0x5555, data 0x55 at 0x2AAA, and data 0xA0, 0x80 or 0x20 at 0x5555.
- R4: The prefix is 0xAA@0x5555, then 0x55@0x2AAA, then 0xA0@0x5555. The prefix alone leaves `prot_on` at 0. The first write after it is forwarded, and `prot_on` reads 1 in the same cycle that this write appears at the outputs.
- R5: With protection set and no prefix or open window, a write that is not a command step is discarded (`prog_we` stays 0).
- R6: With protection set, the first write after a full prefix is forwarded and protection stays set.
- R7: After a write following a prefix, further writes are forwarded while each comes no more than WIN_CYC clock edges after the previous forwarded one. A longer gap closes the window.
- R8: The disable sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. It clears `prot_on` after its last step, and none of its six bytes is forwarded. Writes after it are forwarded again.
- R9: A write that does not match the expected next step returns the matcher to idle. That write is discarded if protection is set and forwarded if protection is clear, and a later write needs a fresh prefix.
- R10: Command addresses are compared on address bits 14:0 only. Bit 15 is ignored.
- R11: `prot_on` rises only when the write after a prefix is taken. It falls only on the final step of the disable sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One write cycle is presented this clock |
| wr_addr | input | ADDR_W (16) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| prog_we | output | 1 | Write enable to the page write controller |
| prog_addr | output | ADDR_W (16) | Address of the forwarded write |
| prog_data | output | DATA_W (8) | Data of the forwarded write |
| prot_on | output | 1 | Software protection mode |

## Verification
The stimulus table runs a series of write patterns:
- Plain writes with protection clear, which must pass.
- The bare prefix, which must not set protection.
- The prefix followed by data, which must set it.
- Unprefixed writes while protected, which must be dropped.
- Prefix addresses with bit 15 set, which tell a 15-bit compare apart from a full-width one.
- A broken prefix under each mode, which tells discard apart from pass-through.
- The full disable sequence, with a write after it.

Window gaps of exactly WIN_CYC edges and one more locate the closing edge to the cycle. A directed reset in the middle of protected operation shows that the mode bit is cleared.

// File: rtl/swp_pkg.sv
package swp_pkg;

    // Command addresses are decoded on this many low address bits.
    localparam int CMP_W = 15;

    // Recognised command steps; the order matches the pattern table index.
    typedef enum logic [2:0] {
        TOK_AA   = 3'd0,
        TOK_55   = 3'd1,
        TOK_A0   = 3'd2,
        TOK_80   = 3'd3,
        TOK_20   = 3'd4,
        TOK_NONE = 3'd5
    } tok_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_ARM  = 3'd3,
        ST_D3   = 3'd4,
        ST_D4   = 3'd5,
        ST_D5   = 3'd6,
        ST_WIN  = 3'd7
    } st_e;

endpackage

// File: rtl/swp_cmd_match.sv
module swp_cmd_match
    import swp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [CMP_W-1:0]  addr,
    input  logic [DATA_W-1:0] data,
    output tok_e              tok
);
    localparam int NPAT = 5;
    localparam logic [CMP_W-1:0]  PAT_A [NPAT] = '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h5555};
    localparam logic [DATA_W-1:0] PAT_D [NPAT] = '{DATA_W'(8'hAA), DATA_W'(8'h55), DATA_W'(8'hA0),
                                                   DATA_W'(8'h80), DATA_W'(8'h20)};

    logic [NPAT-1:0] hit;

    for (genvar g = 0; g < NPAT; g++) begin : g_pat
        assign hit[g] = (addr == PAT_A[g]) && (data == PAT_D[g]);
    end

    always_comb begin
        tok = TOK_NONE;
        for (int i = NPAT - 1; i >= 0; i--) begin
            if (hit[i]) tok = tok_e'(i);
        end
    end

endmodule

// File: rtl/swp_load_window.sv
module swp_load_window #(
    parameter int WIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_MAX;
        end else if (tick && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q <= CNT_W'(1));

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX)
        else $error("window counter above limit");

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == CNT_MAX)
        else $error("window not reloaded");

endmodule

// File: rtl/swp_guard.sv
module swp_guard
    import swp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int WIN_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prog_we,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              prot_on
);
    typedef struct packed {
        st_e               st;
        logic              prot;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_t;

    reg_t d, q;
    tok_e tok;
    logic load, tick, expire, pass, abort;

    swp_cmd_match #(.DATA_W(DATA_W)) match_i (
        .addr (wr_addr[CMP_W-1:0]),
        .data (wr_data),
        .tok  (tok)
    );

    swp_load_window #(.WIN_CYC(WIN_CYC)) win_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .tick   (tick),
        .expire (expire)
    );

    always_comb begin
        d     = q;
        d.we  = 1'b0;
        load  = 1'b0;
        tick  = 1'b0;
        pass  = 1'b0;
        abort = 1'b0;
        if (wr_valid) begin
            case (q.st)
                ST_IDLE: begin
                    if (tok == TOK_AA) d.st = ST_K1;
                    else               pass = !q.prot;
                end
                ST_K1: begin
                    if (tok == TOK_55) d.st = ST_K2;
                    else               abort = 1'b1;
                end
                ST_K2: begin
                    if (tok == TOK_A0)      d.st = ST_ARM;
                    else if (tok == TOK_80) d.st = ST_D3;
                    else                    abort = 1'b1;
                end
                ST_ARM: begin
                    pass   = 1'b1;
                    load   = 1'b1;
                    d.prot = 1'b1;
                    d.st   = ST_WIN;
                end
                ST_D3: begin
                    if (tok == TOK_AA) d.st = ST_D4;
                    else               abort = 1'b1;
                end
                ST_D4: begin
                    if (tok == TOK_55) d.st = ST_D5;
                    else               abort = 1'b1;
                end
                ST_D5: begin
                    if (tok == TOK_20) begin
                        d.prot = 1'b0;
                        d.st   = ST_IDLE;
                    end else begin
                        abort = 1'b1;
                    end
                end
                ST_WIN: begin
                    pass = 1'b1;
                    load = 1'b1;
                end
                default: abort = 1'b1;
            endcase
            if (abort) begin
                d.st = ST_IDLE;
                pass = !q.prot;
            end
        end else if (q.st == ST_WIN) begin
            tick = 1'b1;
            if (expire) d.st = ST_IDLE;
        end
        if (pass) begin
            d.we   = 1'b1;
            d.addr = wr_addr;
            d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, prot: 1'b0, we: 1'b0, addr: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign prog_we   = q.we;
    assign prog_addr = q.addr;
    assign prog_data = q.data;
    assign prot_on   = q.prot;

    p_we_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> $past(wr_valid))
        else $error("enable without a write");

    p_fwd_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> (prog_addr == $past(wr_addr)) && (prog_data == $past(wr_data)))
        else $error("forwarded write differs from input");

    p_cmd_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && q.st == ST_K2 && (tok == TOK_A0 || tok == TOK_80)) |=> !prog_we)
        else $error("command step forwarded");

    p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && q.prot && q.st == ST_IDLE && tok == TOK_NONE) |=> !prog_we)
        else $error("unprefixed write passed while protected");

    p_prot_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(wr_valid && q.st == ST_ARM))
        else $error("protection set outside armed write");

    p_prot_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(wr_valid && q.st == ST_D5) && !prog_we)
        else $error("protection cleared outside disable sequence");

endmodule

// File: tb/swp_guard_tb_top.sv
module swp_guard_tb_top;

    localparam int WIN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_we;
    logic [15:0] prog_addr;
    logic [7:0]  prog_data;
    logic        prot_on;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    swp_guard #(.ADDR_W(16), .DATA_W(8), .WIN_CYC(WIN)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .prot_on   (prot_on)
    );

    typedef struct packed {
        logic [7:0]  gap;
        logic [15:0] a;
        logic [7:0]  d;
        logic        we;
        logic        prot;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        {8'd0,  16'h0100, 8'h11, 1'b1, 1'b0, 4'd2},   // R2 plain write
        {8'd0,  16'h7FFF, 8'hEE, 1'b1, 1'b0, 4'd2},   // R2
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b0, 4'd3},   // R3 step 1
        {8'd0,  16'h2AAA, 8'h55, 1'b0, 1'b0, 4'd3},   // R3 step 2
        {8'd0,  16'h5555, 8'hA0, 1'b0, 1'b0, 4'd4},   // R4 prefix alone
        {8'd0,  16'h0240, 8'h3C, 1'b1, 1'b1, 4'd4},   // R4 data sets mode
        {8'd0,  16'h0241, 8'h3D, 1'b1, 1'b1, 4'd7},   // R7 in window
        {8'd14, 16'h0242, 8'h3E, 1'b1, 1'b1, 4'd7},   // R7 gap == WIN
        {8'd15, 16'h0243, 8'h3F, 1'b0, 1'b1, 4'd7},   // R7 gap == WIN+1
        {8'd0,  16'h0300, 8'h55, 1'b0, 1'b1, 4'd5},   // R5 no prefix
        {8'd0,  16'hD555, 8'hAA, 1'b0, 1'b1, 4'd10},  // R10 bit 15 set
        {8'd0,  16'hAAAA, 8'h55, 1'b0, 1'b1, 4'd10},  // R10
        {8'd0,  16'h5555, 8'hA0, 1'b0, 1'b1, 4'd3},   // R3
        {8'd0,  16'h1234, 8'h99, 1'b1, 1'b1, 4'd6},   // R6 prefixed write
        {8'd15, 16'h1235, 8'h9A, 1'b0, 1'b1, 4'd7},   // R7 closed
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b1, 4'd9},   // R9
        {8'd0,  16'h2AAA, 8'h55, 1'b0, 1'b1, 4'd9},   // R9
        {8'd0,  16'h5555, 8'h12, 1'b0, 1'b1, 4'd9},   // R9 mismatch, dropped
        {8'd0,  16'h0400, 8'h77, 1'b0, 1'b1, 4'd9},   // R9 needs fresh prefix
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b1, 4'd8},   // R8 disable 1
        {8'd0,  16'h2AAA, 8'h55, 1'b0, 1'b1, 4'd8},   // R8 disable 2
        {8'd0,  16'h5555, 8'h80, 1'b0, 1'b1, 4'd8},   // R8 disable 3
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b1, 4'd8},   // R8 disable 4
        {8'd0,  16'h2AAA, 8'h55, 1'b0, 1'b1, 4'd8},   // R8 disable 5
        {8'd0,  16'h5555, 8'h20, 1'b0, 1'b0, 4'd11},  // R11 falls on last step
        {8'd0,  16'h0500, 8'h42, 1'b1, 1'b0, 4'd8},   // R8 writes pass again
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b0, 4'd9},   // R9
        {8'd0,  16'h0600, 8'h01, 1'b1, 1'b0, 4'd9}    // R9 mismatch passes
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one write cycle after `gap` extra idle cycles; returns at the
    // falling edge following the sampling edge, when outputs are settled.
    task automatic do_wr(input int gap, input logic [15:0] a, input logic [7:0] dt);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = dt;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic chk_wr(input string req, input logic we, input logic prot,
                          input logic [15:0] a, input logic [7:0] dt);
        chk(req, "prog_we", 32'(prog_we), 32'(we));
        chk(req, "prot_on", 32'(prot_on), 32'(prot));
        if (we) begin
            chk(req, "prog_addr", 32'(prog_addr), 32'(a));
            chk(req, "prog_data", 32'(prog_data), 32'(dt));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "prog_we in reset", 32'(prog_we), 32'd0);
        chk("R1", "prot_on in reset", 32'(prot_on), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "prog_we after reset", 32'(prog_we), 32'd0);
        chk("R1", "prot_on after reset", 32'(prot_on), 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_wr(int'(VEC[i].gap), VEC[i].a, VEC[i].d);
            chk_wr($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].we, VEC[i].prot, VEC[i].a, VEC[i].d);
        end

        // R1: reset while protected clears the mode
        do_wr(0, 16'h5555, 8'hAA);
        do_wr(0, 16'h2AAA, 8'h55);
        do_wr(0, 16'h5555, 8'hA0);
        do_wr(0, 16'h0777, 8'h5A);
        chk_wr("R4 re-arm", 1'b1, 1'b1, 16'h0777, 8'h5A);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "prot_on during reset", 32'(prot_on), 32'd0);
        chk("R1", "prog_we during reset", 32'(prog_we), 32'd0);
        rst_n = 1'b1;
        do_wr(0, 16'h0888, 8'hC3);
        chk_wr("R1 write passes after reset", 1'b1, 1'b0, 16'h0888, 8'hC3);

        // R2: no enable in an idle cycle after a forwarded write
        @(negedge clk);
        chk("R2", "prog_we idle", 32'(prog_we), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule